// File: doc/BRIEF.md
# Multi-queue grid dispatch scheduler

The scheduler collects grid launch descriptors from a set of independent host submission queues and from a return path used by running compute work to start child grids. Each descriptor carries a grid ID, a priority and, for child grids, the ID of the parent grid. Descriptors wait in per-source FIFOs until an arbiter moves the best candidate into a fixed pool of active slots. The arbiter considers only the oldest entry of each source, takes the highest priority level present and rotates among the sources at that level.

Active grids are offered one at a time on a dispatch port with a valid/ready handshake. A completion pulse carrying a grid ID releases that grid's slot, and the arbiter may refill the slot in the same cycle. A running grid that has launched children can be suspended. It stays parked in its slot until every child it launched has completed, and it is then offered for dispatch again. A global pause input stops new grids from entering the pool and stops new offers, while all queued work stays in place.

Top module: `gds_sched`

## Requirements
- R1: Each of the NQ host queues is a FIFO of QDEPTH entries with its own valid/ready pair. Grids from one queue enter the pool in submission order. `sub_ready[q]` is low exactly while queue q holds QDEPTH entries.
- R2: At most one grid per cycle moves from a source head into the pool. The child path is source index NQ and the host queues are indices 0 to NQ-1. The numerically largest `prio` among non-empty heads wins. Ties go to the first eligible source at or after a rotation pointer, taken modulo NQ+1. The pointer is 0 after reset and becomes the granted index plus one after each grant.
- R3: No more than NSLOTS grids are held in the pool at once. A grid keeps its slot from the moment it is granted until its completion, and queued grids are not lost while the pool is full.
- R4: A `cmp_valid` pulse whose `cmp_id` matches a dispatched grid frees that grid's slot on that clock edge. A queued grid may be granted into the slot on the same edge, so `dsp_valid` for it is high one cycle later.
- R5: Once `dsp_valid` is high, it stays high with `dsp_id` unchanged until `dsp_ready` is seen high. At most one grid is offered per cycle.
- R6: While `pause` is high, no grid is granted into the pool and no new offer is raised. An offer that is already raised is kept. Queued grids all dispatch after `pause` falls.
- R7: The child path takes `ch_id`, `ch_prio` and `ch_parent` under `ch_valid`/`ch_ready`. It buffers CDEPTH entries, and `ch_ready` is low exactly while it is full.
- R8: Each child accepted while its parent occupies a slot adds one to that parent's count of outstanding children. Each completion of such a child subtracts one.
- R9: A `susp_valid` pulse naming a dispatched grid parks that grid. The grid is not offered again until its outstanding-child count is zero, after which it is offered again. A grid that is suspended with no children is offered again promptly.
- R10: After reset, `dsp_valid` is low and every queue ready and `ch_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pause | input | 1 | Stop new grants and new offers |
| sub_valid | input | NQ | Per-queue launch valid |
| sub_ready | output | NQ | Per-queue room available |
| sub_id | input | NQ*IDW | Per-queue grid ID |
| sub_prio | input | NQ*PW | Per-queue grid priority |
| ch_valid | input | 1 | Child launch valid |
| ch_ready | output | 1 | Child path room available |
| ch_id | input | IDW | Child grid ID |
| ch_parent | input | IDW | Parent grid ID of the child |
| ch_prio | input | PW | Child grid priority |
| susp_valid | input | 1 | Suspend pulse for a running grid |
| susp_id | input | IDW | ID of grid to suspend |
| cmp_valid | input | 1 | Completion pulse |
| cmp_id | input | IDW | ID of completed grid |
| dsp_valid | output | 1 | Grid offered to compute units |
| dsp_ready | input | 1 | Compute units accept the offer |
| dsp_id | output | IDW | ID of offered grid |

## Verification
The hardest situation to reach from the ports is a parent that is parked with children still outstanding. The parent must be dispatched and still hold its slot. Children must then be launched that name it, the parent must be suspended, and the children must complete one at a time while the port is watched to see that the parent stays absent until the last one completes. The bench builds this sequence step by step with completions held back. The exact-cycle refill is reached by filling every slot with grids that are never completed while more work waits, then completing one. Arbitration order is swept over several priority patterns with every queue preloaded under pause, and each dispatch sequence is compared with an arithmetic model of the rotation pointer.

// File: rtl/gds_pkg.sv
package gds_pkg;

    typedef enum logic [2:0] {
        SLOT_FREE  = 3'd0,
        SLOT_READY = 3'd1,
        SLOT_OFFER = 3'd2,
        SLOT_RUN   = 3'd3,
        SLOT_SUSP  = 3'd4
    } slot_state_e;

    function automatic int unsigned clog2_min1(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/gds_fifo.sv
module gds_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PTRW = gds_pkg::clog2_min1(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTRW-1:0]         rd;
        logic [PTRW-1:0]         wr;
        logic [CNTW-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr = (st_q.wr == PTRW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == PTRW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rd];
    assign full  = (st_q.cnt == CNTW'(DEPTH));
    assign empty = (st_q.cnt == '0);

endmodule

// File: rtl/gds_arb.sv
module gds_arb #(
    parameter int NSRC = 33,
    parameter int PW   = 2,
    localparam int IW  = gds_pkg::clog2_min1(NSRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           req,
    input  logic [NSRC-1:0][PW-1:0]   prio,
    input  logic                      en,
    output logic                      gnt_v,
    output logic [IW-1:0]             gnt_idx
);
    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [PW-1:0]   top_pr;
    logic [NSRC-1:0] elig;

    always_comb begin
        top_pr = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (prio[i] > top_pr)) top_pr = prio[i];
        end
        for (int i = 0; i < NSRC; i++) begin
            elig[i] = req[i] && (prio[i] == top_pr);
        end
        gnt_v   = 1'b0;
        gnt_idx = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (!gnt_v && elig[(int'(st_q.ptr) + k) % NSRC]) begin
                gnt_v   = 1'b1;
                gnt_idx = IW'((int'(st_q.ptr) + k) % NSRC);
            end
        end
        st_d = st_q;
        if (en && gnt_v) begin
            st_d.ptr = (gnt_idx == IW'(NSRC - 1)) ? '0 : gnt_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/gds_sched.sv
module gds_sched
    import gds_pkg::*;
#(
    parameter int NQ         = 32,
    parameter int QDEPTH     = 2,
    parameter int CDEPTH     = 4,
    parameter int NSLOTS     = 32,
    parameter int IDW        = 8,
    parameter int PW         = 2,
    parameter int CHILD_CNTW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pause,
    input  logic [NQ-1:0]            sub_valid,
    output logic [NQ-1:0]            sub_ready,
    input  logic [NQ-1:0][IDW-1:0]   sub_id,
    input  logic [NQ-1:0][PW-1:0]    sub_prio,
    input  logic                     ch_valid,
    output logic                     ch_ready,
    input  logic [IDW-1:0]           ch_id,
    input  logic [IDW-1:0]           ch_parent,
    input  logic [PW-1:0]            ch_prio,
    input  logic                     susp_valid,
    input  logic [IDW-1:0]           susp_id,
    input  logic                     cmp_valid,
    input  logic [IDW-1:0]           cmp_id,
    output logic                     dsp_valid,
    input  logic                     dsp_ready,
    output logic [IDW-1:0]           dsp_id
);
    localparam int NSRC = NQ + 1;
    localparam int IW   = clog2_min1(NSRC);
    localparam int SW   = clog2_min1(NSLOTS);

    typedef struct packed {
        logic [IDW-1:0] id;
        logic [PW-1:0]  prio;
        logic           has_par;
        logic [IDW-1:0] par;
    } ent_t;

    localparam int EW = $bits(ent_t);

    typedef struct packed {
        slot_state_e           st;
        logic [IDW-1:0]        id;
        logic                  has_par;
        logic [IDW-1:0]        par;
        logic [CHILD_CNTW-1:0] cnt;
    } slot_t;

    typedef struct packed {
        slot_t [NSLOTS-1:0] slot;
        logic               offer_v;
        logic [SW-1:0]      offer_idx;
    } sched_st_t;

    sched_st_t st_d, st_q;

    ent_t [NSRC-1:0]         src_in;
    ent_t [NSRC-1:0]         src_out;
    logic [NSRC-1:0]         src_push;
    logic [NSRC-1:0]         src_pop;
    logic [NSRC-1:0]         src_full;
    logic [NSRC-1:0]         src_empty;
    logic [NSRC-1:0][PW-1:0] arb_prio;
    logic                    arb_en;
    logic                    gnt_v;
    logic [IW-1:0]           gnt_idx;

    // host submission queues
    for (genvar q = 0; q < NQ; q++) begin : g_host
        assign src_in[q]    = '{id: sub_id[q], prio: sub_prio[q], has_par: 1'b0, par: '0};
        assign src_push[q]  = sub_valid[q] && !src_full[q];
        assign sub_ready[q] = !src_full[q];

        gds_fifo #(.W(EW), .DEPTH(QDEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (src_push[q]),
            .din   (src_in[q]),
            .pop   (src_pop[q]),
            .dout  (src_out[q]),
            .full  (src_full[q]),
            .empty (src_empty[q])
        );
    end

    // child launch return path, arbitrated as source NQ
    assign src_in[NQ]   = '{id: ch_id, prio: ch_prio, has_par: 1'b1, par: ch_parent};
    assign src_push[NQ] = ch_valid && !src_full[NQ];
    assign ch_ready     = !src_full[NQ];

    gds_fifo #(.W(EW), .DEPTH(CDEPTH)) u_child_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (src_push[NQ]),
        .din   (src_in[NQ]),
        .pop   (src_pop[NQ]),
        .dout  (src_out[NQ]),
        .full  (src_full[NQ]),
        .empty (src_empty[NQ])
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_prio
        assign arb_prio[i] = src_out[i].prio;
    end

    gds_arb #(.NSRC(NSRC), .PW(PW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (~src_empty),
        .prio    (arb_prio),
        .en      (arb_en),
        .gnt_v   (gnt_v),
        .gnt_idx (gnt_idx)
    );

    logic           accept;
    logic           cmp_par_v;
    logic [IDW-1:0] cmp_par;
    logic           rdy_found;
    logic [SW-1:0]  rdy_idx;
    logic           any_free;
    logic [SW-1:0]  free_idx;

    always_comb begin
        st_d      = st_q;
        src_pop   = '0;
        accept    = st_q.offer_v && dsp_ready;
        cmp_par_v = 1'b0;
        cmp_par   = '0;
        rdy_found = 1'b0;
        rdy_idx   = '0;
        any_free  = 1'b0;
        free_idx  = '0;

        // parked grids with no outstanding children become ready
        for (int s = 0; s < NSLOTS; s++) begin
            if (st_q.slot[s].st == SLOT_SUSP && st_q.slot[s].cnt == '0) begin
                st_d.slot[s].st = SLOT_READY;
            end
        end

        // dispatch handshake
        if (accept) begin
            st_d.slot[st_q.offer_idx].st = SLOT_RUN;
            st_d.offer_v = 1'b0;
        end

        // suspend and completion of running grids
        for (int s = 0; s < NSLOTS; s++) begin
            if (st_q.slot[s].st == SLOT_RUN) begin
                if (susp_valid && st_q.slot[s].id == susp_id) begin
                    st_d.slot[s].st = SLOT_SUSP;
                end
                if (cmp_valid && st_q.slot[s].id == cmp_id) begin
                    st_d.slot[s].st = SLOT_FREE;
                    cmp_par_v = st_q.slot[s].has_par;
                    cmp_par   = st_q.slot[s].par;
                end
            end
        end

        // outstanding-child bookkeeping of parents held in the pool
        for (int s = 0; s < NSLOTS; s++) begin
            if (st_q.slot[s].st != SLOT_FREE) begin
                if (src_push[NQ] && st_q.slot[s].id == ch_parent) begin
                    st_d.slot[s].cnt = st_d.slot[s].cnt + 1'b1;
                end
                if (cmp_par_v && st_q.slot[s].id == cmp_par && st_d.slot[s].cnt != '0) begin
                    st_d.slot[s].cnt = st_d.slot[s].cnt - 1'b1;
                end
            end
        end

        // raise a new offer from the lowest ready slot
        if ((!st_q.offer_v || accept) && !pause) begin
            for (int s = 0; s < NSLOTS; s++) begin
                if (!rdy_found && st_q.slot[s].st == SLOT_READY) begin
                    rdy_found = 1'b1;
                    rdy_idx   = SW'(s);
                end
            end
            if (rdy_found) begin
                st_d.slot[rdy_idx].st = SLOT_OFFER;
                st_d.offer_v          = 1'b1;
                st_d.offer_idx        = rdy_idx;
            end
        end

        // grant a queued grid into the lowest free slot, including one freed now
        for (int s = 0; s < NSLOTS; s++) begin
            if (!any_free && st_d.slot[s].st == SLOT_FREE) begin
                any_free = 1'b1;
                free_idx = SW'(s);
            end
        end
        arb_en = any_free && !pause;
        if (arb_en && gnt_v) begin
            st_d.slot[free_idx].st      = SLOT_READY;
            st_d.slot[free_idx].id      = src_out[gnt_idx].id;
            st_d.slot[free_idx].has_par = src_out[gnt_idx].has_par;
            st_d.slot[free_idx].par     = src_out[gnt_idx].par;
            st_d.slot[free_idx].cnt     = '0;
            src_pop[gnt_idx]            = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dsp_valid = st_q.offer_v;
    assign dsp_id    = st_q.slot[st_q.offer_idx].id;

endmodule

// File: rtl/gds_sched_chk.sv
module gds_sched_chk #(
    parameter int NQ  = 32,
    parameter int IDW = 8,
    localparam int NSRC = NQ + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pause,
    input logic            dsp_valid,
    input logic            dsp_ready,
    input logic [IDW-1:0]  dsp_id,
    input logic [NQ-1:0]   sub_ready,
    input logic            ch_ready,
    input logic [NSRC-1:0] src_pop
);

    assert_offer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_id)));

    assert_pause_no_offer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !dsp_valid) |=> !dsp_valid);

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_pop));

    assert_child_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_ready && !src_pop[NSRC-1]) |=> !ch_ready);

    for (genvar q = 0; q < NQ; q++) begin : g_q
        assert_queue_full_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (!sub_ready[q] && !src_pop[q]) |=> !sub_ready[q]);
    end

endmodule

bind gds_sched gds_sched_chk #(.NQ(NQ), .IDW(IDW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pause     (pause),
    .dsp_valid (dsp_valid),
    .dsp_ready (dsp_ready),
    .dsp_id    (dsp_id),
    .sub_ready (sub_ready),
    .ch_ready  (ch_ready),
    .src_pop   (src_pop)
);

// File: tb/gds_sched_tb.sv
`timescale 1ns/1ps
module gds_sched_tb;
    localparam int NQ = 4, QDEPTH = 2, CDEPTH = 2, NSLOTS = 4, IDW = 6, PW = 2, CCW = 3;
    localparam int NSRC = NQ + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pause = 1'b0;
    logic [NQ-1:0] sub_valid = '0;
    logic [NQ-1:0] sub_ready;
    logic [NQ-1:0][IDW-1:0] sub_id = '0;
    logic [NQ-1:0][PW-1:0] sub_prio = '0;
    logic ch_valid = 1'b0, ch_ready;
    logic [IDW-1:0] ch_id = '0, ch_parent = '0;
    logic [PW-1:0] ch_prio = '0;
    logic susp_valid = 1'b0;
    logic [IDW-1:0] susp_id = '0;
    logic cmp_valid = 1'b0;
    logic [IDW-1:0] cmp_id = '0;
    logic dsp_valid, dsp_ready = 1'b0;
    logic [IDW-1:0] dsp_id;

    int checks = 0, failures = 0;
    int got[16];
    int got_n;
    int exp_ord[8];
    int rr_ptr = 0;

    always #2 clk = ~clk;

    gds_sched #(.NQ(NQ), .QDEPTH(QDEPTH), .CDEPTH(CDEPTH), .NSLOTS(NSLOTS),
                .IDW(IDW), .PW(PW), .CHILD_CNTW(CCW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pause(pause),
        .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_id(sub_id), .sub_prio(sub_prio),
        .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_id(ch_id), .ch_parent(ch_parent),
        .ch_prio(ch_prio), .susp_valid(susp_valid), .susp_id(susp_id),
        .cmp_valid(cmp_valid), .cmp_id(cmp_id),
        .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_id(dsp_id));

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    function automatic int pr(input int pat, input int q, input int k);
        case (pat)
            0: return 0;
            1: return q;
            2: return (q * 3 + k) % 4;
            default: return (k == 0) ? (q % 2) * 3 : 3;
        endcase
    endfunction

    // collect dispatched IDs, optionally completing each one a cycle later
    task automatic drain(input int maxcyc, input bit autoc);
        bit pv = 1'b0;
        int pid = 0;
        got_n = 0;
        for (int c = 0; c < maxcyc; c++) begin
            @(negedge clk);
            cmp_valid = pv && autoc;
            cmp_id = IDW'(pid);
            pv = 1'b0;
            if (dsp_valid && dsp_ready) begin
                if (got_n < 16) got[got_n] = int'(dsp_id);
                got_n++;
                pv = 1'b1;
                pid = int'(dsp_id);
            end
        end
        @(negedge clk);
        cmp_valid = pv && autoc;
        cmp_id = IDW'(pid);
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic complete(input int id);
        @(negedge clk);
        cmp_valid = 1'b1;
        cmp_id = IDW'(id);
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic model(input int pat);
        int hd[NQ];
        for (int q = 0; q < NQ; q++) hd[q] = 0;
        for (int n = 0; n < 2 * NQ; n++) begin
            int best = -1;
            int pick = -1;
            for (int q = 0; q < NQ; q++)
                if (hd[q] < 2 && pr(pat, q, hd[q]) > best) best = pr(pat, q, hd[q]);
            for (int i = 0; i < NSRC; i++) begin
                int s = (rr_ptr + i) % NSRC;
                if (pick < 0 && s < NQ && hd[s] < 2 && pr(pat, s, hd[s]) == best) pick = s;
            end
            exp_ord[n] = pick * 2 + hd[pick] + 1;
            hd[pick]++;
            rr_ptr = (pick + 1) % NSRC;
        end
    endtask

    initial begin
        int r[4];
        int id5;
        repeat (3) @(negedge clk);
        chk(dsp_valid == 1'b0, "R10 dsp_valid in reset", int'(dsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dsp_valid == 1'b0, "R10 dsp_valid after reset", int'(dsp_valid), 0);
        chk(sub_ready == '1, "R10 sub_ready after reset", int'(sub_ready), 15);
        chk(ch_ready == 1'b1, "R10 ch_ready after reset", int'(ch_ready), 1);

        // arbitration sweep over priority patterns
        for (int pat = 0; pat < 4; pat++) begin
            pause = 1'b1;
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                sub_valid = '1;
                for (int q = 0; q < NQ; q++) begin
                    sub_id[q] = IDW'(q * 2 + k + 1);
                    sub_prio[q] = PW'(pr(pat, q, k));
                end
            end
            @(negedge clk);
            sub_valid = '0;
            chk(sub_ready == '0, "R1 all queues full", int'(sub_ready), 0);
            repeat (4) @(negedge clk);
            chk(dsp_valid == 1'b0, "R6 paused no offer", int'(dsp_valid), 0);
            model(pat);
            dsp_ready = 1'b1;
            pause = 1'b0;
            drain(40, 1'b1);
            chk(got_n == 8, "R3 all sweep grids dispatched", got_n, 8);
            for (int n = 0; n < 8; n++)
                chk(got[n] == exp_ord[n], "R2 grant order", got[n], exp_ord[n]);
            if (pat == 1)
                for (int n = 0; n < 8; n += 2)
                    chk(got[n] + 1 == got[n + 1], "R1 in-queue order", got[n + 1], got[n] + 1);
        end

        // backpressure and pause retention
        pause = 1'b1;
        @(negedge clk);
        sub_valid = 4'b0001; sub_id[0] = 6'd1; sub_prio[0] = '0;
        ch_valid = 1'b1; ch_id = 6'd3; ch_parent = 6'd63; ch_prio = '0;
        @(negedge clk);
        sub_id[0] = 6'd2; ch_id = 6'd4;
        @(negedge clk);
        sub_valid = '0; ch_valid = 1'b0;
        chk(sub_ready == 4'b1110, "R1 only queue 0 full", int'(sub_ready), 14);
        chk(ch_ready == 1'b0, "R7 child path full", int'(ch_ready), 0);
        got_n = 0;
        for (int c = 0; c < 15; c++) begin
            @(negedge clk);
            if (dsp_valid) got_n++;
        end
        chk(got_n == 0, "R6 no offer while paused", got_n, 0);
        pause = 1'b0;
        drain(40, 1'b1);
        chk(got_n == 4, "R6 queued grids kept across pause", got_n, 4);
        chk(ch_ready == 1'b1, "R7 child path drained", int'(ch_ready), 1);

        // offer hold
        dsp_ready = 1'b0;
        @(negedge clk);
        sub_valid = 4'b1000; sub_id[3] = 6'd40; sub_prio[3] = 2'd1;
        @(negedge clk);
        sub_valid = '0;
        repeat (4) @(negedge clk);
        chk(dsp_valid == 1'b1 && dsp_id == 6'd40, "R5 offer raised", int'(dsp_id), 40);
        repeat (3) @(negedge clk);
        chk(dsp_valid == 1'b1 && dsp_id == 6'd40, "R5 offer held", int'(dsp_id), 40);
        dsp_ready = 1'b1;
        @(negedge clk);
        chk(dsp_valid == 1'b0, "R5 offer dropped after accept", int'(dsp_valid), 0);
        cmp_valid = 1'b1; cmp_id = 6'd40;
        @(negedge clk);
        cmp_valid = 1'b0;

        // pool limit and same-cycle refill
        pause = 1'b1;
        @(negedge clk);
        sub_valid = 4'b0111;
        sub_id[0] = 6'd1; sub_id[1] = 6'd3; sub_id[2] = 6'd5;
        sub_prio[0] = '0; sub_prio[1] = '0; sub_prio[2] = '0;
        @(negedge clk);
        sub_valid = 4'b0011; sub_id[0] = 6'd2; sub_id[1] = 6'd4;
        @(negedge clk);
        sub_valid = '0;
        pause = 1'b0;
        drain(20, 1'b0);
        chk(got_n == NSLOTS, "R3 pool limited to slot count", got_n, NSLOTS);
        for (int i = 0; i < 4; i++) r[i] = got[i];
        @(negedge clk);
        cmp_valid = 1'b1; cmp_id = IDW'(r[0]);
        @(negedge clk);
        cmp_valid = 1'b0;
        chk(dsp_valid == 1'b0, "R4 no offer on completion edge", int'(dsp_valid), 0);
        @(negedge clk);
        chk(dsp_valid == 1'b1, "R4 refilled grid offered next cycle", int'(dsp_valid), 1);
        id5 = int'(dsp_id);
        chk(id5 == 15 - r[0] - r[1] - r[2] - r[3], "R3 waiting grid kept", id5,
            15 - r[0] - r[1] - r[2] - r[3]);
        complete(id5);
        for (int i = 1; i < 4; i++) complete(r[i]);

        // parent parked until children complete
        @(negedge clk);
        sub_valid = 4'b0010; sub_id[1] = 6'd20; sub_prio[1] = 2'd1;
        @(negedge clk);
        sub_valid = '0;
        drain(10, 1'b0);
        chk(got_n == 1 && got[0] == 20, "R9 parent dispatched", got[0], 20);
        @(negedge clk);
        ch_valid = 1'b1; ch_id = 6'd21; ch_parent = 6'd20; ch_prio = '0;
        @(negedge clk);
        ch_id = 6'd22;
        @(negedge clk);
        ch_valid = 1'b0;
        drain(10, 1'b0);
        chk(got_n == 2, "R7 children dispatched", got_n, 2);
        chk(got[0] == 21 && got[1] == 22, "R7 child order", got[1], 22);
        @(negedge clk);
        susp_valid = 1'b1; susp_id = 6'd20;
        @(negedge clk);
        susp_valid = 1'b0;
        drain(8, 1'b0);
        chk(got_n == 0, "R9 parked parent not offered", got_n, 0);
        complete(21);
        drain(10, 1'b0);
        chk(got_n == 0, "R8 one child still outstanding", got_n, 0);
        complete(22);
        drain(10, 1'b0);
        chk(got_n == 1 && got[0] == 20, "R8 parent redispatched after last child", got[0], 20);
        complete(20);

        // suspend with no children
        @(negedge clk);
        sub_valid = 4'b0100; sub_id[2] = 6'd30; sub_prio[2] = '0;
        @(negedge clk);
        sub_valid = '0;
        drain(10, 1'b0);
        chk(got_n == 1 && got[0] == 30, "R9 grid dispatched", got[0], 30);
        @(negedge clk);
        susp_valid = 1'b1; susp_id = 6'd30;
        @(negedge clk);
        susp_valid = 1'b0;
        drain(10, 1'b0);
        chk(got_n == 1 && got[0] == 30, "R9 childless grid redispatched", got[0], 30);
        complete(30);

        repeat (4) @(negedge clk);
        report();
    end

endmodule